// File: doc/BRIEF.md
# Precomputation-Gated Magnitude Comparator

This block reports whether the unsigned operand A is greater than the unsigned operand B. Both operands arrive in parallel together with a valid strobe, and the block captures them on the clock edge where the strobe is high. To cut switching activity, it splits each operand into its top bit and its lower bits. A small register holds the two top bits and loads on every valid sample. A wider register holds the two lower-bit fields and loads only when the two top bits match. When the top bits differ, they already settle the answer, so the wide register and the lower-bit compare logic stay idle.

The answer comes from the captured state and is visible in the cycle that follows the sampling edge. A debug output shows whether the wide register took a new value on the most recent valid sample. The operand width is a parameter. The gating logic sits in a control module that drives the datapath through a small struct of load strobes.

Top module: `precompCmp`

## Requirements
- R1: While reset (rstN low, asynchronous) is active and after it is released with no valid sample yet, gtOut is 0 and lowLoadedOut is 0.
- R2: After a valid sample where the top bits of A and B differ, gtOut becomes 1 exactly when the top bit of A is 1 and the top bit of B is 0. This holds whatever the lower bits are and whatever the lower-bit register still holds.
- R3: After a valid sample where the top bits of A and B are equal, gtOut equals the unsigned comparison A > B of the lower WIDTH-1 bits.
- R4: The lower-bit register loads only on a valid sample with equal top bits. lowLoadedOut is 1 after such a sample and 0 after a valid sample with differing top bits.
- R5: A cycle with validIn low changes neither gtOut nor lowLoadedOut.
- R6: After a valid sample with A equal to B, including all-zero and all-one operands, gtOut is 0 and lowLoadedOut is 1.
- R7: Outputs reflect a valid sample in the cycle right after the sampling edge, so back-to-back valid samples give one result per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Operands are sampled on this cycle's edge |
| aIn | input | WIDTH | Unsigned operand A |
| bIn | input | WIDTH | Unsigned operand B |
| gtOut | output | 1 | 1 when the captured A is greater than the captured B |
| lowLoadedOut | output | 1 | 1 when the last valid sample loaded the lower-bit register |

## Verification
The bench builds two instances: one with the default 16-bit width and one with WIDTH set to 2. The wide instance exercises long lower-bit compares. In it, stale lower bits left over from earlier samples differ from the new operands, so any leak of those bits into a result decided by the top bits alone shows up. The 2-bit instance shrinks the lower field to a single bit. Random stimulus then covers every combination of top and lower bits, including equal operands and sequences where the gated register holds across several differing-top samples.

// File: rtl/precompCmp_pkg.sv
package precompCmp_pkg;
  typedef struct packed {
    logic loadTop;  // capture the top bits of both operands
    logic loadLow;  // capture the lower bits of both operands
  } cmpStrobes_t;
endpackage

// File: rtl/precompCtrl.sv
module precompCtrl
  import precompCmp_pkg::*;
(
  input  logic        validIn,
  input  logic        topA,
  input  logic        topB,
  output cmpStrobes_t strobes
);
  logic topsMatch;

  // Precompute function: the lower bits matter only when the tops tie.
  always_comb begin
    topsMatch       = ~(topA ^ topB);
    strobes.loadTop = validIn;
    strobes.loadLow = validIn & topsMatch;
  end
endmodule

// File: rtl/lowCompare.sv
module lowCompare #(
  parameter int LOW_W = 15
) (
  input  logic [LOW_W-1:0] lowA,
  input  logic [LOW_W-1:0] lowB,
  output logic             lowGt
);
  logic [LOW_W:0] gtChain;

  assign gtChain[0] = 1'b0;

  // Ripple from the least significant bit: a higher bit overrides the rest.
  for (genvar i = 0; i < LOW_W; i++) begin : g_bit
    assign gtChain[i+1] = (lowA[i] & ~lowB[i]) |
                          (~(lowA[i] ^ lowB[i]) & gtChain[i]);
  end

  assign lowGt = gtChain[LOW_W];
endmodule

// File: rtl/precompDatapath.sv
module precompDatapath
  import precompCmp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmpStrobes_t      strobes,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic             gtOut,
  output logic             lowLoadedOut
);
  localparam int LOW_W = WIDTH - 1;

  logic             topAQ, topBQ;
  logic [LOW_W-1:0] lowAQ, lowBQ;
  logic             lowLoadedQ;
  logic             lowGt;

  // Small register: always loaded on a valid sample.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topAQ      <= 1'b0;
      topBQ      <= 1'b0;
      lowLoadedQ <= 1'b0;
    end else if (strobes.loadTop) begin
      topAQ      <= aIn[WIDTH-1];
      topBQ      <= bIn[WIDTH-1];
      lowLoadedQ <= strobes.loadLow;
    end
  end

  // Wide register: load suppressed when the top bits decide the result.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowAQ <= '0;
      lowBQ <= '0;
    end else if (strobes.loadLow) begin
      lowAQ <= aIn[LOW_W-1:0];
      lowBQ <= bIn[LOW_W-1:0];
    end
  end

  lowCompare #(.LOW_W(LOW_W)) u_lowCompare (
    .lowA (lowAQ),
    .lowB (lowBQ),
    .lowGt(lowGt)
  );

  always_comb begin
    if (topAQ != topBQ) gtOut = topAQ;
    else                gtOut = lowGt;
  end

  assign lowLoadedOut = lowLoadedQ;

  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadLow |=> ($stable(lowAQ) && $stable(lowBQ)))
    else $error("lower register changed without load"); // R4

  AST_LOADED_MEANS_TIE: assert property (@(posedge clk) disable iff (!rstN)
    lowLoadedOut |-> (topAQ == topBQ))
    else $error("lower load flagged with differing tops"); // R4

  AST_TOP_DECIDES: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadTop && (aIn[WIDTH-1] != bIn[WIDTH-1])) |=> (gtOut == $past(aIn[WIDTH-1])))
    else $error("differing tops gave wrong result"); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadTop |=> ($stable(gtOut) && $stable(lowLoadedOut)))
    else $error("outputs moved without valid"); // R5

  AST_EQUAL_NOT_GT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadTop && (aIn == bIn)) |=> (!gtOut && lowLoadedOut))
    else $error("equal operands gave greater"); // R6
endmodule

// File: rtl/precompCmp.sv
module precompCmp
  import precompCmp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic             gtOut,
  output logic             lowLoadedOut
);
  cmpStrobes_t strobes;

  initial begin
    AST_WIDTH_OK: assert (WIDTH >= 2) else $error("WIDTH must be at least 2"); // R3
  end

  precompCtrl u_ctrl (
    .validIn(validIn),
    .topA   (aIn[WIDTH-1]),
    .topB   (bIn[WIDTH-1]),
    .strobes(strobes)
  );

  precompDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .aIn         (aIn),
    .bIn         (bIn),
    .gtOut       (gtOut),
    .lowLoadedOut(lowLoadedOut)
  );
endmodule

// File: tb/precompCmp_test.sv
`timescale 1ns/1ps
module precompCmp_test;
  localparam int W = 16;
  localparam int WN = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic gtOut, lowLoadedOut;
  logic gtOutN, lowLoadedOutN;

  int testCount = 0;
  int failCount = 0;
  bit expGt = 0, expLd = 0, expGtN = 0, expLdN = 0;
  bit done = 0;

  always #10 clk = ~clk;

  precompCmp #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .aIn(aIn), .bIn(bIn),
    .gtOut(gtOut), .lowLoadedOut(lowLoadedOut));

  precompCmp #(.WIDTH(WN)) uutNarrow (
    .clk(clk), .rstN(rstN), .validIn(validIn), .aIn(aIn[WN-1:0]), .bIn(bIn[WN-1:0]),
    .gtOut(gtOutN), .lowLoadedOut(lowLoadedOutN));

  task automatic check(string tag, string what, logic act, logic exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0b expected %0b (a=%h b=%h)", tag, what, act, exp, aIn, bIn);
    end
  endtask

  function automatic string tagFor(logic [W-1:0] a, logic [W-1:0] b, int wd);
    logic [W-1:0] m;
    m = (W'(1) << wd) - 1;
    if ((a & m) == (b & m)) return "R6";
    if (a[wd-1] != b[wd-1]) return "R2";
    return "R3";
  endfunction

  // One clock: drive at negedge, model updates at the edge, compare at next negedge.
  task automatic step(logic v, logic [W-1:0] a, logic [W-1:0] b);
    string tW, tN;
    validIn = v; aIn = a; bIn = b;
    tW = v ? tagFor(a, b, W)  : "R5";
    tN = v ? tagFor(a, b, WN) : "R5";
    @(posedge clk);
    if (v) begin
      expGt  = (a > b);
      expLd  = (a[W-1] == b[W-1]);
      expGtN = (a[WN-1:0] > b[WN-1:0]);
      expLdN = (a[WN-1] == b[WN-1]);
    end
    @(negedge clk);
    check(tW, "gt wide R7", gtOut, expGt);
    check(v ? "R4" : "R5", "loaded wide", lowLoadedOut, expLd);
    check(tN, "gt narrow R7", gtOutN, expGtN);
    check(v ? "R4" : "R5", "loaded narrow", lowLoadedOutN, expLdN);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    aIn = 16'hFFFF; bIn = 16'h0000; validIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "gt in reset", gtOut, 1'b0);
    check("R1", "loaded in reset", lowLoadedOut, 1'b0);
    validIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "gt after reset", gtOut, 1'b0);
    check("R1", "loaded after reset", lowLoadedOut, 1'b0);

    // Corner vectors
    step(1, 16'h0000, 16'h0000);   // R6 all-zero
    step(1, 16'hFFFF, 16'hFFFF);   // R6 all-one
    step(1, 16'h7FFF, 16'h0001);   // R3 tops tie
    step(1, 16'h0001, 16'h7FFF);   // R3
    step(1, 16'h8000, 16'h7FFF);   // R2 stale lows must not matter
    step(1, 16'h0000, 16'hFFFF);   // R2
    step(0, 16'hFFFF, 16'h0000);   // R5 idle
    step(0, 16'h0000, 16'h0000);   // R5 idle
    step(1, 16'h8001, 16'h8000);   // R3 one-lsb difference
    step(1, 16'h1234, 16'h1234);   // R6
    // Stale lower bits greater, tops differ: result from tops only (R2)
    step(1, 16'h7FFE, 16'h7FFF);
    step(1, 16'h0000, 16'h8000);
    step(1, 16'hFFFF, 16'h0000);

    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      if (i % 4 == 0) b[W-1] = a[W-1];
      if (i % 9 == 0) b = a;
      step(($urandom % 5) != 0, a, b);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule